// File: doc/BRIEF.md
# Multi-Mode Capture/Reload Timer

A 16-bit timer/counter that a peripheral subsystem uses for interval timing, event counting, timestamping of an external edge, serial bit-rate generation and a square-wave output. The count advances from one of three sources. In timer function it advances on a machine-cycle enable, which is one pulse every 12 oscillator periods. In baud and clock-out operation it advances on a state enable, one pulse every 2 oscillator periods. In counter function it advances on a sampled falling edge of an external count pin. A 16-bit companion register holds either a captured count or the value loaded into the count when it wraps.

Configuration arrives as static level inputs. They select the mode, the count source, the trigger enable, up/down counting, the receive and transmit baud selections and the clock output. Software-style writes to the count and to the companion register come through write strobes with data. Two sticky flags drive the interrupt request: an overflow flag and an external-event flag. Each is cleared by its own clear input. The external trigger pin changes meaning with the mode. It can be a capture strobe, a reload strobe, a count-direction level or a plain interrupt source.

Top module: `tm16_timer`

## Requirements
- R1: After reset, count, companion register, both flags, irq, rx_tick, tx_tick and clk_out are all 0.
- R2: The mode is picked in this order. With run low the timer is off and the count holds. Otherwise, rx_sel or tx_sel high selects baud mode. Otherwise, clko_en high with cnt_sel low selects clock-out mode. Otherwise, cap_sel high selects capture mode. Otherwise, down_en high selects up/down mode. Otherwise the mode is up-count reload.
- R3: With cnt_sel low, the count rises by one on every ce_mach pulse in capture and reload modes, and by one on every ce_state pulse in baud and clock-out modes. In capture mode the count wraps from FFFFh to 0000h and sets the overflow flag.
- R4: Both pins are sampled on ce_mach. With cnt_sel high, the count advances on a ce_mach pulse only when the previous sample of cnt_pin was 1 and the pin is now 0. The sample register is 0 after reset.
- R5: In capture mode with ext_en high, a falling trigger sample (the previous sample 1, now 0, at ce_mach) copies the current count into the companion register and sets the external flag. The count itself is not changed by the edge.
- R6: In up-count reload mode, a step from FFFFh loads the companion value and sets the overflow flag. With ext_en high, a falling trigger sample loads the companion value and sets the external flag, and it takes precedence over a step in the same cycle.
- R7: In up/down mode the last trigger sample sets the direction: 1 counts up, 0 counts down. Counting up from FFFFh loads the companion value. Counting down when the count equals the companion value loads FFFFh. Both wraps set the overflow flag and invert the external flag. The external flag is not part of irq in this mode, and trigger edges cause no load.
- R8: In baud and clock-out modes, a step from FFFFh loads the companion value without setting the overflow flag. With ext_en high, a falling trigger sample sets the external flag and does not load the count.
- R9: In baud and clock-out modes every wrap advances a 16-step divider. On every 16th wrap, rx_tick pulses for one cycle if rx_sel is high and tx_sel likewise gates tx_tick.
- R10: clk_out toggles on each wrap when clko_en is high and cnt_sel is low. It holds otherwise.
- R11: irq is the OR of the overflow flag and the external flag, except in up/down mode, where irq follows the overflow flag alone. The flags stay set until ovf_clr or ext_clr. A set in the same cycle wins over a clear.
- R12: count_wr loads count_din and reload_wr loads reload_din. Each write overrides the count, reload or capture update of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_mach | input | 1 | Machine-cycle enable (1 in 12 oscillator periods) |
| ce_state | input | 1 | State enable (1 in 2 oscillator periods) |
| cnt_pin | input | 1 | External count pin |
| trg_pin | input | 1 | External trigger / direction pin |
| run | input | 1 | Run enable |
| cnt_sel | input | 1 | 1 = counter function, 0 = timer function |
| cap_sel | input | 1 | 1 = capture, 0 = reload |
| ext_en | input | 1 | Enables trigger-edge events |
| down_en | input | 1 | Enables up/down counting in reload mode |
| rx_sel | input | 1 | Receive baud clock taken from this timer |
| tx_sel | input | 1 | Transmit baud clock taken from this timer |
| clko_en | input | 1 | Clock output enable |
| count_wr | input | 1 | Count write strobe |
| count_din | input | 16 | Count write data |
| reload_wr | input | 1 | Companion register write strobe |
| reload_din | input | 16 | Companion register write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| ext_clr | input | 1 | Clears the external flag |
| count | output | 16 | Current count |
| capture | output | 16 | Companion capture/reload register |
| ovf_flag | output | 1 | Overflow / underflow flag |
| ext_flag | output | 1 | External-event flag |
| irq | output | 1 | Interrupt request |
| rx_tick | output | 1 | Receive baud tick |
| tx_tick | output | 1 | Transmit baud tick |
| clk_out | output | 1 | 50% duty clock output |

## Verification
Each mode runs with the count preset a few steps below FFFFh, so wraps occur often. Both pins are toggled randomly at a rate that sometimes beats the machine-cycle sampling and sometimes does not. Missed and caught edges therefore separate true sampled-edge detection from raw pin following. In up/down mode the direction pin flips while the count sits between the companion value and FFFFh. This separates the underflow compare from a zero compare, and it exposes a wrong wrap target in either direction. Runs with only one baud select set, and with the clock output requested in counter function, show whether gating is applied per output. A final phase draws random configurations, writes and flag clears, to test the mode priority and the precedence of set over clear.

// File: rtl/tm16_pkg.sv
package tm16_pkg;

  typedef enum logic [2:0] {
    MD_OFF  = 3'd0,
    MD_CAPT = 3'd1,
    MD_RLD  = 3'd2,
    MD_UPDN = 3'd3,
    MD_BAUD = 3'd4,
    MD_CLKO = 3'd5
  } tm_mode_e;

  typedef struct packed {
    logic run;
    logic cnt_sel;
    logic cap_sel;
    logic ext_en;
    logic down_en;
    logic rx_sel;
    logic tx_sel;
    logic clko_en;
  } tm_cfg_t;

endpackage

// File: rtl/tm16_mode_dec.sv
module tm16_mode_dec
  import tm16_pkg::*;
(
  input  tm_cfg_t  cfg,
  output tm_mode_e mode,
  output logic     fast
);

  // Priority order matters (R2): off, baud, clock-out, capture, up/down, reload.
  always_comb begin
    if (!cfg.run)                          mode = MD_OFF;
    else if (cfg.rx_sel || cfg.tx_sel)     mode = MD_BAUD;
    else if (cfg.clko_en && !cfg.cnt_sel)  mode = MD_CLKO;
    else if (cfg.cap_sel)                  mode = MD_CAPT;
    else if (cfg.down_en)                  mode = MD_UPDN;
    else                                   mode = MD_RLD;
  end

  assign fast = (mode == MD_BAUD) || (mode == MD_CLKO);

endmodule

// File: rtl/tm16_pin_smp.sv
module tm16_pin_smp (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic pin,
  output logic level,
  output logic fall
);

  logic smp_q, smp_n;

  always_comb begin
    smp_n = smp_q;
    if (ce) smp_n = pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b0;
    else        smp_q <= smp_n;
  end

  assign level = smp_q;
  assign fall  = ce & smp_q & ~pin;

endmodule

// File: rtl/tm16_count_core.sv
module tm16_count_core
  import tm16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tm_mode_e         mode,
  input  logic             tick,
  input  logic             trg_fall,
  input  logic             dir_up,
  input  logic             ext_en,
  input  logic             count_wr,
  input  logic [WIDTH-1:0] count_din,
  input  logic             reload_wr,
  input  logic [WIDTH-1:0] reload_din,
  input  logic             ovf_clr,
  input  logic             ext_clr,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] cap,
  output logic             ovf,
  output logic             ext,
  output logic             wrap
);

  localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_n, cap_q, cap_n;
  logic             ovf_q, ovf_n, ext_q, ext_n;
  logic             ovf_set, ext_set, ext_tgl;
  logic             at_max, at_cap, trg_ev;

  assign at_max = (cnt_q == ALL1);
  assign at_cap = (cnt_q == cap_q);
  assign trg_ev = ext_en & trg_fall;

  always_comb begin
    cnt_n   = cnt_q;
    cap_n   = cap_q;
    ovf_set = 1'b0;
    ext_set = 1'b0;
    ext_tgl = 1'b0;
    wrap    = 1'b0;
    unique case (mode)
      MD_CAPT: begin
        if (tick) begin
          cnt_n   = cnt_q + ONE;
          ovf_set = at_max;
        end
        if (trg_ev) begin
          cap_n   = cnt_q;
          ext_set = 1'b1;
        end
      end
      MD_RLD: begin
        if (trg_ev) begin
          cnt_n   = cap_q;
          ext_set = 1'b1;
        end else if (tick) begin
          cnt_n   = at_max ? cap_q : cnt_q + ONE;
          ovf_set = at_max;
        end
      end
      MD_UPDN: begin
        if (tick) begin
          if (dir_up) begin
            cnt_n   = at_max ? cap_q : cnt_q + ONE;
            ovf_set = at_max;
            ext_tgl = at_max;
          end else begin
            cnt_n   = at_cap ? ALL1 : cnt_q - ONE;
            ovf_set = at_cap;
            ext_tgl = at_cap;
          end
        end
      end
      MD_BAUD, MD_CLKO: begin
        if (tick) begin
          cnt_n = at_max ? cap_q : cnt_q + ONE;
          wrap  = at_max;
        end
        if (trg_ev) ext_set = 1'b1;
      end
      default: ;
    endcase
    if (count_wr)  cnt_n = count_din;
    if (reload_wr) cap_n = reload_din;
    ovf_n = ovf_set | (ovf_q & ~ovf_clr);
    ext_n = ext_tgl ? ~ext_q : (ext_set | (ext_q & ~ext_clr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      ovf_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      cap_q <= cap_n;
      ovf_q <= ovf_n;
      ext_q <= ext_n;
    end
  end

  assign cnt = cnt_q;
  assign cap = cap_q;
  assign ovf = ovf_q;
  assign ext = ext_q;

  p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_OFF && !count_wr) |=> $stable(cnt_q));

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_CAPT && ext_en && trg_fall && !reload_wr) |=> (cap_q == $past(cnt_q) && ext_q));

  p_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_UPDN && tick && !dir_up && cnt_q == cap_q && !count_wr) |=> (cnt_q == ALL1 && ovf_q));

  p_no_ovf_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MD_BAUD || mode == MD_CLKO) && !ovf_q) |=> !ovf_q);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

endmodule

// File: rtl/tm16_baud_out.sv
module tm16_baud_out #(
  parameter int DIV_BITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic rx_sel,
  input  logic tx_sel,
  input  logic clko_gate,
  output logic rx_tick,
  output logic tx_tick,
  output logic clk_out
);

  localparam logic [DIV_BITS-1:0] DIV_TOP = {DIV_BITS{1'b1}};

  logic [DIV_BITS-1:0] div_q, div_n;
  logic rx_q, rx_n, tx_q, tx_n, clk_q, clk_n, last;

  always_comb begin
    last  = wrap && (div_q == DIV_TOP);
    div_n = wrap ? div_q + DIV_BITS'(1) : div_q;
    rx_n  = last & rx_sel;
    tx_n  = last & tx_sel;
    clk_n = (wrap & clko_gate) ? ~clk_q : clk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      div_q <= div_n;
      rx_q  <= rx_n;
      tx_q  <= tx_n;
      clk_q <= clk_n;
    end
  end

  assign rx_tick = rx_q;
  assign tx_tick = tx_q;
  assign clk_out = clk_q;

  p_rx_after_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_q |-> $past(wrap));

  p_clk_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_q) |-> $past(wrap));

endmodule

// File: rtl/tm16_timer.sv
module tm16_timer
  import tm16_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int DIV_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_mach,
  input  logic             ce_state,
  input  logic             cnt_pin,
  input  logic             trg_pin,
  input  logic             run,
  input  logic             cnt_sel,
  input  logic             cap_sel,
  input  logic             ext_en,
  input  logic             down_en,
  input  logic             rx_sel,
  input  logic             tx_sel,
  input  logic             clko_en,
  input  logic             count_wr,
  input  logic [WIDTH-1:0] count_din,
  input  logic             reload_wr,
  input  logic [WIDTH-1:0] reload_din,
  input  logic             ovf_clr,
  input  logic             ext_clr,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capture,
  output logic             ovf_flag,
  output logic             ext_flag,
  output logic             irq,
  output logic             rx_tick,
  output logic             tx_tick,
  output logic             clk_out
);

  tm_cfg_t  cfg;
  tm_mode_e mode;
  logic     fast, tick, wrap;
  logic     cnt_lvl, cnt_fall, trg_lvl, trg_fall;

  assign cfg = '{run: run, cnt_sel: cnt_sel, cap_sel: cap_sel, ext_en: ext_en,
                 down_en: down_en, rx_sel: rx_sel, tx_sel: tx_sel, clko_en: clko_en};

  tm16_mode_dec u_dec (.cfg(cfg), .mode(mode), .fast(fast));

  tm16_pin_smp u_cnt_smp (.clk(clk), .rst_n(rst_n), .ce(ce_mach), .pin(cnt_pin),
                          .level(cnt_lvl), .fall(cnt_fall));
  tm16_pin_smp u_trg_smp (.clk(clk), .rst_n(rst_n), .ce(ce_mach), .pin(trg_pin),
                          .level(trg_lvl), .fall(trg_fall));

  // Step source: sampled pin edge, state rate or machine-cycle rate.
  always_comb begin
    if (mode == MD_OFF) tick = 1'b0;
    else if (cnt_sel)   tick = cnt_fall;
    else if (fast)      tick = ce_state;
    else                tick = ce_mach;
  end

  tm16_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .trg_fall(trg_fall),
    .dir_up(trg_lvl), .ext_en(ext_en), .count_wr(count_wr), .count_din(count_din),
    .reload_wr(reload_wr), .reload_din(reload_din), .ovf_clr(ovf_clr),
    .ext_clr(ext_clr), .cnt(count), .cap(capture), .ovf(ovf_flag), .ext(ext_flag),
    .wrap(wrap)
  );

  tm16_baud_out #(.DIV_BITS(DIV_BITS)) u_baud (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .rx_sel(rx_sel), .tx_sel(tx_sel),
    .clko_gate(clko_en & ~cnt_sel), .rx_tick(rx_tick), .tx_tick(tx_tick),
    .clk_out(clk_out)
  );

  // In up/down mode the external flag is a 17th count bit, not a request.
  assign irq = ovf_flag | (ext_flag & (mode != MD_UPDN));

  p_cnt_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_fall |=> !cnt_lvl);

endmodule

// File: tb/test_tm16_timer.sv
module test_tm16_timer;

  logic        clk, rst_n;
  logic        ce_mach, ce_state, cnt_pin, trg_pin;
  logic        run, cnt_sel, cap_sel, ext_en, down_en, rx_sel, tx_sel, clko_en;
  logic        count_wr, reload_wr, ovf_clr, ext_clr;
  logic [15:0] count_din, reload_din, count, capture;
  logic        ovf_flag, ext_flag, irq, rx_tick, tx_tick, clk_out;

  int total = 0, bad = 0, ph = 0;
  int k_cnt = 0, k_trg = 0, k_clr = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  logic [15:0] m_cnt, m_cap;
  logic        m_ovf, m_ext, m_smpc, m_smpt, m_rx, m_tx, m_clk;
  logic [3:0]  m_div;

  tm16_timer i_tm16_timer (.*);

  initial clk = 0;
  always #10 clk = ~clk;

  // R2 priority: 0 off, 1 capture, 2 reload, 3 up/down, 4 baud, 5 clock-out
  function automatic int mode_of();
    if (!run) return 0;
    if (rx_sel || tx_sel) return 4;
    if (clko_en && !cnt_sel) return 5;
    if (cap_sel) return 1;
    if (down_en) return 3;
    return 2;
  endfunction

  function automatic logic exp_irq();
    return m_ovf | (m_ext & (mode_of() != 3));
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [15:0] nc, ncap;
    logic sov, sex, tgl, wr, cf, tf, tk, t16;
    int md;
    if (!rst_n) begin
      m_cnt <= 0; m_cap <= 0; m_ovf <= 0; m_ext <= 0; m_smpc <= 0; m_smpt <= 0;
      m_rx <= 0; m_tx <= 0; m_clk <= 0; m_div <= 0;
    end else begin
      cf = ce_mach && m_smpc && !cnt_pin;
      tf = ce_mach && m_smpt && !trg_pin && ext_en;
      md = mode_of();
      tk = (md != 0) && (cnt_sel ? cf : ((md >= 4) ? ce_state : ce_mach));
      nc = m_cnt; ncap = m_cap; sov = 0; sex = 0; tgl = 0; wr = 0;
      case (md)
        1: begin
          if (tk) begin nc = m_cnt + 1; sov = (m_cnt == 16'hFFFF); end
          if (tf) begin ncap = m_cnt; sex = 1; end
        end
        2: begin
          if (tf) begin nc = m_cap; sex = 1; end
          else if (tk) begin
            if (m_cnt == 16'hFFFF) begin nc = m_cap; sov = 1; end else nc = m_cnt + 1;
          end
        end
        3: if (tk) begin
          if (m_smpt) begin
            if (m_cnt == 16'hFFFF) begin nc = m_cap; sov = 1; tgl = 1; end else nc = m_cnt + 1;
          end else begin
            if (m_cnt == m_cap) begin nc = 16'hFFFF; sov = 1; tgl = 1; end else nc = m_cnt - 1;
          end
        end
        4, 5: begin
          if (tk) begin
            if (m_cnt == 16'hFFFF) begin nc = m_cap; wr = 1; end else nc = m_cnt + 1;
          end
          if (tf) sex = 1;
        end
        default: ;
      endcase
      if (count_wr) nc = count_din;
      if (reload_wr) ncap = reload_din;
      m_cnt <= nc; m_cap <= ncap;
      m_ovf <= sov | (m_ovf & ~ovf_clr);
      m_ext <= tgl ? ~m_ext : (sex | (m_ext & ~ext_clr));
      if (ce_mach) begin m_smpc <= cnt_pin; m_smpt <= trg_pin; end
      t16 = wr && (m_div == 4'hF);
      if (wr) m_div <= m_div + 1;
      m_rx <= t16 & rx_sel;
      m_tx <= t16 & tx_sel;
      if (wr && clko_en && !cnt_sel) m_clk <= ~m_clk;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(cur_req, "count", count, m_cnt);
    chk(cur_req, "capture", capture, m_cap);
    chk(cur_req, "ovf_flag", ovf_flag, m_ovf);
    chk(cur_req, "ext_flag", ext_flag, m_ext);
    chk(cur_req, "irq", irq, exp_irq());
    chk(cur_req, "rx_tick", rx_tick, m_rx);
    chk(cur_req, "tx_tick", tx_tick, m_tx);
    chk(cur_req, "clk_out", clk_out, m_clk);
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
    ph = (ph + 1) % 12;
    ce_mach  = (ph == 0);
    ce_state = (ph % 2 == 0);
    count_wr = 0; reload_wr = 0;
    if (k_cnt != 0 && $urandom_range(k_cnt - 1) == 0) cnt_pin = ~cnt_pin;
    if (k_trg != 0 && $urandom_range(k_trg - 1) == 0) trg_pin = ~trg_pin;
    ovf_clr = (k_clr != 0) && ($urandom_range(k_clr - 1) == 0);
    ext_clr = (k_clr != 0) && ($urandom_range(k_clr - 1) == 0);
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_both(logic [15:0] c, logic [15:0] r);
    step();
    count_wr = 1; count_din = c; reload_wr = 1; reload_din = r;
    step();
  endtask

  task automatic set_cfg(bit r, bit cs, bit cp, bit ee, bit de, bit rx, bit tx, bit co);
    run = r; cnt_sel = cs; cap_sel = cp; ext_en = ee; down_en = de;
    rx_sel = rx; tx_sel = tx; clko_en = co;
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0;
    {ce_mach, ce_state, cnt_pin, trg_pin} = '0;
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
    {count_wr, reload_wr, ovf_clr, ext_clr} = '0;
    count_din = 0; reload_din = 0;
    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    chk("R1", "count", count, 0);
    chk("R1", "capture", capture, 0);
    chk("R1", "flags", {ovf_flag, ext_flag, irq}, 0);
    chk("R1", "outs", {rx_tick, tx_tick, clk_out}, 0);
    rst_n = 1;

    cur_req = "R12";
    write_both(16'hFFF0, 16'hFF00);
    chk("R12", "count write", count, 16'hFFF0);
    chk("R12", "reload write", capture, 16'hFF00);

    cur_req = "R2"; k_cnt = 4; k_trg = 6;
    set_cfg(0, 0, 1, 1, 0, 0, 0, 1);
    run_n(120);
    chk("R2", "off hold", count, 16'hFFF0);

    cur_req = "R3"; k_trg = 0;
    set_cfg(1, 0, 1, 0, 0, 0, 0, 0);
    run_n(400);

    cur_req = "R6"; k_trg = 20; k_clr = 60;
    write_both(16'hFFF8, 16'hFFF0);
    set_cfg(1, 0, 0, 1, 0, 0, 0, 0);
    run_n(700);

    cur_req = "R4"; k_cnt = 8;
    set_cfg(1, 1, 0, 0, 0, 0, 0, 0);
    run_n(900);

    cur_req = "R5"; k_trg = 15;
    write_both(16'hFFE0, 16'h0000);
    set_cfg(1, 0, 1, 1, 0, 0, 0, 0);
    run_n(700);

    cur_req = "R7"; k_trg = 40;
    write_both(16'hFFF4, 16'hFFF0);
    set_cfg(1, 0, 0, 1, 1, 0, 0, 0);
    run_n(1800);

    cur_req = "R8"; k_trg = 25;
    write_both(16'hFFF0, 16'hFFF0);
    set_cfg(1, 0, 0, 1, 0, 1, 1, 0);
    run_n(3000);

    cur_req = "R9";
    set_cfg(1, 0, 0, 1, 0, 1, 0, 0);
    run_n(1200);
    set_cfg(1, 0, 0, 1, 0, 0, 1, 0);
    run_n(1200);

    cur_req = "R10";
    write_both(16'hFFFC, 16'hFFFC);
    set_cfg(1, 0, 0, 0, 0, 0, 0, 1);
    run_n(600);
    set_cfg(1, 1, 0, 0, 0, 0, 0, 1);
    run_n(400);

    cur_req = "R11"; k_clr = 25;
    for (int b = 0; b < 30; b++) begin
      set_cfg($urandom_range(9) != 0, $urandom_range(3) == 0, $urandom_range(1),
              $urandom_range(1), $urandom_range(1), $urandom_range(4) == 0,
              $urandom_range(4) == 0, $urandom_range(2) == 0);
      for (int i = 0; i < 150; i++) begin
        step();
        if ($urandom_range(99) == 0) begin
          count_wr = 1; count_din = 16'hFF00 | 16'($urandom_range(255));
        end
        if ($urandom_range(99) == 0) begin
          reload_wr = 1; reload_din = 16'hFF00 | 16'($urandom_range(255));
        end
      end
    end
    step();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule